// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block is a small fully associative table that lets a scheduler hoist a load above earlier stores. When a load is issued ahead of those stores, it records its destination register tag and the doubleword it read. Every store that follows compares its address against all live entries in parallel and kills any entry that covers the same doubleword. When the program reaches the point where the load would have run, a check on the destination register asks the table whether the entry is still live.

A live entry means no store touched the loaded data, so execution goes on. A killed entry, or one that was never recorded or was pushed out, asks for a branch to recovery code. Losing an entry therefore costs only a needless recovery, never a wrong result. The check response comes one cycle after the query.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table holds no live entry and `rsp_valid`, `rsp_hit` and `rsp_fixup` are low. A check made right after reset answers fixup.
- R2: An insert records its tag and the address bits above bit 2 (the doubleword). A later check of that tag, with no store in between that matches, answers hit.
- R3: A store kills every live entry whose address bits above bit 2 equal the store's, whatever the low three bits are. Entries for other doublewords stay live.
- R4: A check of a tag whose entry a store has killed answers fixup.
- R5: A check of a tag that has no entry answers fixup.
- R6: An insert for a tag that already has a live entry overwrites that entry, so only the new address counts. It uses no other slot.
- R7: An insert for a new tag takes the lowest-numbered free slot. When there is no free slot, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement. A check of the tag that was pushed out answers fixup.
- R8: When a store and a check arrive in the same cycle, the store's kill is applied first, so the check answers fixup if the store matched the entry.
- R9: When an insert and a store arrive in the same cycle, the inserted entry is live afterwards even if the addresses match. A check in the same cycle as an insert sees the table as it was before that insert.
- R10: Each check yields exactly one response, one cycle later: `rsp_valid` high with exactly one of `rsp_hit` and `rsp_fixup` high. With no check the response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Advanced load inserts an entry |
| ins_tag | input | 7 | Destination register tag of the load |
| ins_addr | input | 64 | Byte address read by the load |
| st_valid | input | 1 | Store snoop request |
| st_addr | input | 64 | Byte address of the store |
| chk_valid | input | 1 | Check query |
| chk_tag | input | 7 | Register tag being checked |
| rsp_valid | output | 1 | Check response present |
| rsp_hit | output | 1 | Entry live, continue |
| rsp_fixup | output | 1 | Entry killed or absent, branch to recovery |

## Verification
The hardest state to reach is a full table in which the round-robin victim and the lowest free slot have both been steered by earlier kills and overwrites. The bench reaches it by running a mix of inserts, kills and overwrites first, then pouring in more distinct tags than there are slots. It keeps a model of the slot assignment built from R6 and R7, and checks every tag to find which ones were pushed out. Same-cycle collisions of store with check, insert with store and insert with check are each driven directly.

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES  = 16,
  parameter int TAG_W    = 7,
  parameter int ADDR_W   = 64,
  parameter int LINE_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fixup
);
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LINE_W = ADDR_W - LINE_LSB;
  localparam int CNT_W  = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [LINE_W-1:0]  st_line, ins_line;
  logic [ENTRIES-1:0] st_kill, tag_hit, chk_match;
  logic               hit_any, free_any;
  logic [IDX_W-1:0]   hit_idx, free_idx, ins_idx;

  assign st_line  = st_addr[ADDR_W-1:LINE_LSB];
  assign ins_line = ins_addr[ADDR_W-1:LINE_LSB];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign st_kill[i]   = st_valid && vld[i] && (line_q[i] == st_line);
    assign tag_hit[i]   = vld[i] && (tag_q[i] == ins_tag);
    assign chk_match[i] = vld[i] && !st_kill[i] && (tag_q[i] == chk_tag);
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign ins_idx = hit_any ? hit_idx : (free_any ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      rr_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (st_kill[i]) vld[i] <= 1'b0;
        if (ins_valid && ins_idx == IDX_W'(i)) begin
          vld[i]    <= 1'b1;
          tag_q[i]  <= ins_tag;
          line_q[i] <= ins_line;
        end
      end
      if (ins_valid && !hit_any && !free_any)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fixup <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      rsp_hit   <= chk_valid && (|chk_match);
      rsp_fixup <= chk_valid && !(|chk_match);
    end
  end

  // checker state for the assertions below
  logic [LINE_W-1:0]  prev_st_line;
  logic [TAG_W-1:0]   prev_ins_tag;
  logic [ENTRIES-1:0] line_left, tag_left;
  logic [CNT_W-1:0]   occ;

  always_ff @(posedge clk) begin
    prev_st_line <= st_line;
    prev_ins_tag <= ins_tag;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    assign line_left[i] = vld[i] && (line_q[i] == prev_st_line);
    assign tag_left[i]  = vld[i] && (tag_q[i] == prev_ins_tag);
  end
  assign occ = CNT_W'($countones(vld));

  assert_rsp_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_fixup));
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_fixup));
  assert_store_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ins_valid) |=> (line_left == '0));
  assert_insert_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> ($countones(tag_left) == 1));
  assert_no_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> (occ >= $past(occ)));
  assert_fill_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !st_valid && !hit_any && free_any) |=> (occ == $past(occ) + 1'b1));
endmodule

// File: tb/tb_spec_load_table.sv
module tb_spec_load_table;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
  logic [6:0]  ins_tag = '0, chk_tag = '0;
  logic [63:0] ins_addr = '0, st_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_fixup;

  int vectors = 0;
  int errors  = 0;

  typedef struct { logic hit; string req; logic [6:0] tag; } exp_t;
  exp_t q[$];

  logic        m_vld [N];
  logic [6:0]  m_tag [N];
  logic [60:0] m_line[N];
  int          m_rr;

  spec_load_table dut (.*);

  always #5 clk = ~clk;

  initial begin
    #100us;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      vectors++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected response, got valid=1 expected valid=0");
      end else begin
        e = q.pop_front();
        if (rsp_hit !== e.hit || rsp_fixup !== !e.hit) begin
          errors++;
          $display("FAIL %s: tag %0d got hit=%b fixup=%b expected hit=%b fixup=%b",
                   e.req, e.tag, rsp_hit, rsp_fixup, e.hit, !e.hit);
        end
      end
    end
  end

  function automatic logic model_live(logic [6:0] t, logic sv, logic [63:0] sa);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_tag[i] == t && !(sv && m_line[i] == sa[63:3])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(logic iv, logic [6:0] it, logic [63:0] ia,
                      logic sv, logic [63:0] sa,
                      logic cv, logic [6:0] ct, string req);
    int idx;
    if (cv) begin
      exp_t e;
      e.hit = model_live(ct, sv, sa);
      e.req = req;
      e.tag = ct;
      q.push_back(e);
    end
    idx = -1;
    if (iv) begin
      for (int i = N - 1; i >= 0; i--) if (m_vld[i] && m_tag[i] == it) idx = i;
      if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) idx = i;
      if (idx < 0) begin
        idx = m_rr;
        m_rr = (m_rr + 1) % N;
      end
    end
    if (sv) for (int i = 0; i < N; i++) if (m_vld[i] && m_line[i] == sa[63:3]) m_vld[i] = 1'b0;
    if (iv) begin
      m_vld[idx] = 1'b1;
      m_tag[idx] = it;
      m_line[idx] = ia[63:3];
    end
    ins_valid = iv; ins_tag = it; ins_addr = ia;
    st_valid = sv;  st_addr = sa;
    chk_valid = cv; chk_tag = ct;
    @(posedge clk);
    #1;
    ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic ins(logic [6:0] t, logic [63:0] a);
    step(1'b1, t, a, 1'b0, '0, 1'b0, '0, "R2");
  endtask
  task automatic st(logic [63:0] a);
    step(1'b0, '0, '0, 1'b1, a, 1'b0, '0, "R3");
  endtask
  task automatic chk(logic [6:0] t, string req);
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, t, req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_rr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fixup !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs got %b%b%b expected 000", rsp_valid, rsp_hit, rsp_fixup);
    end
    @(posedge clk); #1;
    chk(7'd5, "R1");
    ins(7'd1, 64'h1000);
    chk(7'd1, "R2");
    chk(7'd2, "R5");
    ins(7'd2, 64'h2000);
    st(64'h2007);
    chk(7'd2, "R4");
    chk(7'd1, "R3");
    ins(7'd3, 64'h3000);
    st(64'h3008);
    chk(7'd3, "R3");
    ins(7'd8, 64'h8000);
    ins(7'd9, 64'h8003);
    st(64'h8005);
    chk(7'd8, "R3");
    chk(7'd9, "R3");
    ins(7'd4, 64'h4000);
    step(1'b0, '0, '0, 1'b1, 64'h4004, 1'b1, 7'd4, "R8");
    step(1'b1, 7'd6, 64'h6000, 1'b1, 64'h6000, 1'b0, '0, "R9");
    chk(7'd6, "R9");
    step(1'b1, 7'd7, 64'h7000, 1'b0, '0, 1'b1, 7'd7, "R9");
    chk(7'd7, "R9");
    ins(7'd1, 64'h1100);
    st(64'h1000);
    chk(7'd1, "R6");
    st(64'h1100);
    chk(7'd1, "R6");
    for (int k = 0; k < N + 3; k++) ins(7'(32 + k), 64'h10000 + 64'(k * 8));
    st(64'h10010);
    ins(7'd100, 64'h20000);
    ins(7'd101, 64'h20008);
    for (int k = 0; k < N + 3; k++) chk(7'(32 + k), "R7");
    chk(7'd100, "R7");
    chk(7'd101, "R7");
    chk(7'd3, "R7");
    for (int k = 0; k < N; k++) ins(7'(64 + (k % 4)), 64'h30000 + 64'(k * 8));
    for (int k = 0; k < 4; k++) chk(7'(64 + k), "R6");
    chk(7'd100, "R7");
    repeat (3) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10: missing responses, got %0d pending expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule